// File: doc/BRIEF.md
# Radix-4 Signed-Digit Adder/Subtractor

This block adds or subtracts two words held in radix-4 signed-digit form and returns the result in the same form. Each digit lies in -3..+3, so a word of `NUM_DIGITS` digits covers every integer from -(4^n - 1) to +(4^n - 1). Most values have more than one valid encoding. That redundancy lets each digit position settle its result from its own operand digits and a single transfer from the position directly below it. No carry chain runs across the word, so the delay is close to four full-adder delays however wide the word is.

The block is purely combinational. Every position forms the sum of its two operand digits. From that sum it picks a transfer of -1, 0 or +1 for the next higher position, and it keeps an interim digit. It then adds the transfer coming up from below. In subtract mode, every digit of the second operand is negated before the digit sums are formed. The transfer out of the top position is dropped, so the result is exact only up to a multiple of 4^n. Detecting overflow and converting to two's complement are left to the surrounding logic.

Top module: `sd4_adder`

## Requirements
- R1: Digit i of each packed operand and of the result sits in bits [3i+2:3i] as a 3-bit two's complement value. The word's value is the sum of digit_i * 4^i.
- R2: With sub_i = 0, the result value equals value(a_i) + value(b_i) whenever the two operand digits of the top position sum to -1, 0 or +1.
- R3: With sub_i = 1, the result value equals value(a_i) - value(b_i) whenever the top-position digit of a_i minus that of b_i is -1, 0 or +1.
- R4: Every result digit lies in -3..+3. The code 3'b100 is never produced.
- R5: Result digit 0 lies in -2..+2 and is congruent modulo 4 to the digit-0 operand sum (after negation in subtract mode), because nothing enters the lowest position.
- R6: A position whose digit sum is at least 2 passes +1 upward and keeps sum - 4. A sum of -2 or less passes -1 and keeps sum + 4. Any other sum passes 0 and keeps the sum. For example, 1+1 in digit 0 gives result digits 0 = -2 and 1 = +1.
- R7: For all operands, the result value is congruent modulo 4^NUM_DIGITS to value(a_i) plus or minus value(b_i). The transfer out of the top digit is discarded.
- R8: Two all-zero operands give an all-zero result in either mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 3*NUM_DIGITS | First operand, packed signed digits |
| b_i | input | 3*NUM_DIGITS | Second operand, packed signed digits |
| sub_i | input | 1 | 1 selects a_i - b_i, 0 selects a_i + b_i |
| sum_o | output | 3*NUM_DIGITS | Result, packed signed digits |

## Verification
The checker evaluates its assertions every time the inputs change. They cover four things: the digit range of the result, the congruence of the result with the true sum or difference modulo 4^n, the behaviour of the lowest digit that no transfer reaches, and the zero case. Only the bench scenarios can show the exact value when the top position produces no transfer, which encoding the transfer rule picks (checked digit by digit against hand-worked vectors), and the wrap-around at the extremes when the top transfer is dropped.

// File: rtl/sd4_pkg.sv
package sd4_pkg;
  localparam int unsigned DIGIT_W = 3;
  typedef logic signed [DIGIT_W-1:0] digit_t;
  typedef logic signed [DIGIT_W:0]   dsum_t;
  typedef logic signed [1:0]         xfer_t;
endpackage

// File: rtl/sd4_negate.sv
module sd4_negate
  import sd4_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = 8,
  localparam int unsigned VEC_W = DIGIT_W * NUM_DIGITS
) (
  input  logic [VEC_W-1:0] vec_i,
  input  logic             neg_i,
  output logic [VEC_W-1:0] vec_o
);
  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_dig
    digit_t d;
    assign d = digit_t'(vec_i[DIGIT_W*i +: DIGIT_W]);
    assign vec_o[DIGIT_W*i +: DIGIT_W] = neg_i ? -d : d;
  end
endmodule

// File: rtl/sd4_slice.sv
module sd4_slice
  import sd4_pkg::*;
(
  input  digit_t x_i,
  input  digit_t y_i,
  output xfer_t  t_o,
  output digit_t w_o
);
  localparam dsum_t P_HI = 4'sd2;
  localparam dsum_t P_LO = -4'sd2;
  localparam dsum_t RADIX = 4'sd4;

  dsum_t p, w_full;

  always_comb begin
    p = dsum_t'(x_i) + dsum_t'(y_i);
    if (p >= P_HI) begin
      t_o    = 2'sd1;
      w_full = p - RADIX;
    end else if (p <= P_LO) begin
      t_o    = -2'sd1;
      w_full = p + RADIX;
    end else begin
      t_o    = 2'sd0;
      w_full = p;
    end
  end

  // interim digit is within -2..+2 here, so the top bit is redundant
  assign w_o = w_full[DIGIT_W-1:0];
endmodule

// File: rtl/sd4_adder.sv
module sd4_adder
  import sd4_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = 8,
  localparam int unsigned VEC_W = DIGIT_W * NUM_DIGITS
) (
  input  logic [VEC_W-1:0] a_i,
  input  logic [VEC_W-1:0] b_i,
  input  logic             sub_i,
  output logic [VEC_W-1:0] sum_o
);
  logic [VEC_W-1:0] b_eff;
  xfer_t  xfer [NUM_DIGITS];
  digit_t wdig [NUM_DIGITS];
  xfer_t  top_xfer_unused;

  sd4_negate #(.NUM_DIGITS(NUM_DIGITS)) i_negate (
    .vec_i(b_i),
    .neg_i(sub_i),
    .vec_o(b_eff)
  );

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_pos
    sd4_slice i_slice (
      .x_i(digit_t'(a_i[DIGIT_W*i +: DIGIT_W])),
      .y_i(digit_t'(b_eff[DIGIT_W*i +: DIGIT_W])),
      .t_o(xfer[i]),
      .w_o(wdig[i])
    );
    if (i == 0) begin : g_lsd
      assign sum_o[DIGIT_W*i +: DIGIT_W] = wdig[i];
    end else begin : g_up
      assign sum_o[DIGIT_W*i +: DIGIT_W] = wdig[i] + digit_t'(xfer[i-1]);
    end
  end

  assign top_xfer_unused = xfer[NUM_DIGITS-1];
endmodule

// File: rtl/sd4_adder_chk.sv
module sd4_adder_chk #(
  parameter int unsigned NUM_DIGITS = 8,
  localparam int unsigned VEC_W = 3 * NUM_DIGITS,
  localparam int unsigned VAL_W = 2 * NUM_DIGITS + 4
) (
  input logic [VEC_W-1:0] a_i,
  input logic [VEC_W-1:0] b_i,
  input logic             sub_i,
  input logic [VEC_W-1:0] sum_o
);
  typedef logic signed [VAL_W-1:0] val_t;
  localparam val_t MOD_MASK = val_t'((val_t'(1) <<< (2 * NUM_DIGITS)) - 1);

  val_t va, vb, vs, diff;
  logic signed [3:0] p0, r0;

  always_comb begin
    va = '0;
    vb = '0;
    vs = '0;
    for (int i = 0; i < NUM_DIGITS; i++) begin
      va = va + (val_t'($signed(a_i[3*i +: 3])) <<< (2*i));
      vb = vb + (val_t'($signed(b_i[3*i +: 3])) <<< (2*i));
      vs = vs + (val_t'($signed(sum_o[3*i +: 3])) <<< (2*i));
      a_r4_digit_range: assert (sum_o[3*i +: 3] != 3'b100)
        else $error("R4: digit %0d out of range", i);
    end
    diff = (sub_i ? va - vb : va + vb) - vs;
    a_r7_mod_congruent: assert ((diff & MOD_MASK) == '0)
      else $error("R7: result not congruent");
    p0 = 4'($signed(a_i[2:0])) + (sub_i ? -4'($signed(b_i[2:0])) : 4'($signed(b_i[2:0])));
    r0 = 4'($signed(sum_o[2:0]));
    a_r5_low_digit: assert (r0 >= -4'sd2 && r0 <= 4'sd2 && (((p0 - r0) & 4'sd3) == 4'sd0))
      else $error("R5: low digit wrong");
    if (a_i == '0 && b_i == '0) begin
      a_r8_zero: assert (sum_o == '0) else $error("R8: zero case");
    end
  end
endmodule

bind sd4_adder sd4_adder_chk #(.NUM_DIGITS(NUM_DIGITS)) i_sd4_adder_chk (
  .a_i(a_i),
  .b_i(b_i),
  .sub_i(sub_i),
  .sum_o(sum_o)
);

// File: tb/test_sd4_adder.sv
module test_sd4_adder;
  localparam int unsigned N = 8;
  localparam int unsigned W = 3 * N;
  localparam longint MODV = longint'(1) << (2 * N);

  logic clk = 1'b0;
  logic [W-1:0] a, b, s;
  logic sub;
  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct {
    logic [W-1:0] a, b;
    logic         sub;
    bit           has_vec;
    logic [W-1:0] exp_vec;
    string        tag;
  } item_t;
  item_t q[$];

  always #4 clk = ~clk;

  sd4_adder #(.NUM_DIGITS(N)) i_sd4_adder (.a_i(a), .b_i(b), .sub_i(sub), .sum_o(s));

  function automatic longint sd_val(logic [W-1:0] v);
    longint r = 0;
    for (int i = 0; i < N; i++) r += longint'($signed(v[3*i +: 3])) * (longint'(1) << (2*i));
    return r;
  endfunction

  function automatic logic [W-1:0] dv(int pos, int val);
    logic [W-1:0] r = '0;
    r[3*pos +: 3] = 3'(val);
    return r;
  endfunction

  function automatic logic [W-1:0] rnd_vec();
    logic [W-1:0] r;
    for (int i = 0; i < N; i++) r[3*i +: 3] = 3'(int'($urandom_range(6)) - 3);
    return r;
  endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic drive(logic [W-1:0] av, logic [W-1:0] bv, logic sv, bit hv,
                       logic [W-1:0] ev, string tag);
    item_t it;
    @(posedge clk);
    a = av; b = bv; sub = sv;
    it.a = av; it.b = bv; it.sub = sv; it.has_vec = hv; it.exp_vec = ev; it.tag = tag;
    q.push_back(it);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        item_t it = q.pop_front();
        longint tv = it.sub ? sd_val(it.a) - sd_val(it.b) : sd_val(it.a) + sd_val(it.b);
        longint rv = sd_val(s);
        int ta = int'($signed(it.a[W-3 +: 3]));
        int tb = int'($signed(it.b[W-3 +: 3]));
        int pt = it.sub ? ta - tb : ta + tb;
        bit rng = 1;
        for (int i = 0; i < N; i++) if (s[3*i +: 3] == 3'b100) rng = 0;
        check(rng, "R4 digit range", longint'(s), 0);
        check((((tv - rv) % MODV) + MODV) % MODV == 0, "R7 modular", rv, tv);
        if (pt >= -1 && pt <= 1)
          check(rv == tv, it.sub ? "R3 subtract exact" : "R2 add exact", rv, tv);
        if (it.has_vec)
          check(s == it.exp_vec, it.tag, longint'(s), longint'(it.exp_vec));
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    logic [W-1:0] all3;
    a = '0; b = '0; sub = 1'b0;
    all3 = '0;
    for (int i = 0; i < N - 1; i++) all3 |= dv(i, 3);
    drive('0, '0, 1'b0, 1, '0, "R8 zero add");
    drive('0, '0, 1'b1, 1, '0, "R8 zero sub");
    drive(dv(0, 1), dv(0, 1), 1'b0, 1, dv(0, -2) | dv(1, 1), "R6 sum 2");
    drive(dv(0, -1), dv(0, -1), 1'b0, 1, dv(0, 2) | dv(1, -1), "R6 sum -2");
    drive(dv(0, 1), '0, 1'b0, 1, dv(0, 1), "R6 no transfer");
    drive(all3, dv(0, 1), 1'b0, 1, dv(N-1, 1), "R6 transfer chain");
    drive(dv(0, 3), dv(0, 3), 1'b0, 1, dv(0, 2) | dv(1, 1), "R5 sum 6");
    drive(dv(0, 2), dv(0, 3), 1'b1, 1, dv(0, -1), "R3 small diff");
    drive(dv(2, 1), dv(0, -3), 1'b0, 1, dv(0, 1) | dv(1, -1) | dv(2, 1), "R1 packing");
    drive({N{3'b011}}, {N{3'b011}}, 1'b0, 0, '0, "R7");
    drive({N{3'b101}}, {N{3'b011}}, 1'b1, 0, '0, "R7");
    for (int k = 0; k < 300; k++) drive(rnd_vec(), rnd_vec(), 1'b0, 0, '0, "R2");
    for (int k = 0; k < 300; k++) drive(rnd_vec(), rnd_vec(), 1'b1, 0, '0, "R3");
    repeat (3) @(posedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule